// File: doc/BRIEF.md
# Time Base and Decrementer Unit

This block keeps a 64-bit time base that counts up and a 32-bit decrementer that counts down. Both move on one shared tick. Two configuration inputs decide where the tick comes from. When the run input is low, nothing counts. When it is high, the source input picks either every core clock cycle or each rising edge of an external reference clock. The external clock is brought into the core domain through a synchronizer and an edge detector.

Software loads the counters, a reload value, a small control register and a status register through one write port that takes one word per cycle. When the decrementer steps from 1 to 0 it sets a sticky status flag. The interrupt output is the flag gated by an enable bit. If auto-reload is enabled, the decrementer takes the reload value on the tick after it reaches 0. Otherwise it stays at 0.

Top module: `tbd_unit`

## Requirements
- R1: After reset the time base, decrementer, reload value, control bits and status flag are all zero, and `dec_irq` is low.
- R2: While `cfg_run` is 0, neither counter changes except through a software write.
- R3: With `cfg_run`=1 and `cfg_ext`=0, both counters take one step on every core clock cycle.
- R4: With `cfg_run`=1 and `cfg_ext`=1, both counters take exactly one step for each rising edge of `ext_tb_clk`, after a two-stage synchronizer. A level held high gives no further steps.
- R5: The time base counts up by one per tick across its full 64 bits. The carry passes from the low word into the high word, and the count wraps from all ones to zero.
- R6: On each tick a nonzero decrementer drops by one. The tick that moves it from 1 to 0 sets the status flag.
- R7: With auto-reload off, the decrementer stays at 0 on later ticks.
- R8: With auto-reload on (control bit 22, address 4), a tick that finds the decrementer at 0 loads the reload value (address 3).
- R9: The status flag is sticky. Writing a word with bit 0 set to address 5 clears it, a word with bit 0 clear leaves it alone, and an expiry in the same cycle as a clear leaves the flag set.
- R10: `dec_irq` is high exactly when the status flag is set and the interrupt enable (control bit 26, address 4) is 1.
- R11: A write to a counter in the same cycle as a tick stores the written value and skips that step. Address 0 holds the low time-base word, address 1 the high word, and address 2 the decrementer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_run | input | 1 | Enables the counting tick |
| cfg_ext | input | 1 | 0: tick every core cycle, 1: tick on external clock edges |
| ext_tb_clk | input | 1 | External time-base reference clock, asynchronous |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | 3 | Write target (0 TB low, 1 TB high, 2 decrementer, 3 reload, 4 control, 5 status clear) |
| wr_data | input | 32 | Write data |
| tb_value | output | 64 | Current time base |
| dec_value | output | 32 | Current decrementer |
| dec_status | output | 1 | Sticky expiry flag |
| dec_irq | output | 1 | Decrementer interrupt request |

## Verification
The assertions check the following on every cycle:
- no tick appears while counting is off;
- the time base either advances by exactly one or holds, depending on the tick;
- external-source ticks never occur on back-to-back cycles;
- a 1-to-0 step always leaves the flag set;
- a decrementer at 0 without reload stays put;
- the interrupt never rises without both the flag and the enable;
- a decrementer write always lands.

The bench scenarios cover what a single-cycle property cannot:
- the exact number of steps across a burst of external edges and a held level;
- carry and wrap of the time base;
- full decrementer sequences with reload values swept;
- the set-over-clear collision in the status flag.

// File: rtl/tbd_pkg.sv
package tbd_pkg;
  typedef enum logic [2:0] {
    ADDR_TB_LO  = 3'd0,
    ADDR_TB_HI  = 3'd1,
    ADDR_DEC    = 3'd2,
    ADDR_RELOAD = 3'd3,
    ADDR_CTRL   = 3'd4,
    ADDR_STAT   = 3'd5
  } tbd_addr_e;

  localparam int CTRL_IE_BIT  = 26;
  localparam int CTRL_ARE_BIT = 22;
  localparam int STAT_DEC_BIT = 0;
endpackage

// File: rtl/tbd_tick_gen.sv
module tbd_tick_gen #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic sel_ext,
  input  logic ext_clk,
  output logic tick
);
  localparam int LAST = SYNC_STAGES - 1;

  logic [SYNC_STAGES-1:0] sync_q;
  logic                   ext_prev_q;
  logic                   ext_rise;

  for (genvar g = 0; g < SYNC_STAGES; g++) begin : g_sync
    if (g == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q[0] <= 1'b0;
        else        sync_q[0] <= ext_clk;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q[g] <= 1'b0;
        else        sync_q[g] <= sync_q[g-1];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ext_prev_q <= 1'b0;
    else        ext_prev_q <= sync_q[LAST];
  end

  assign ext_rise = sync_q[LAST] & ~ext_prev_q;

  always_comb begin
    tick = 1'b0;
    if (run) tick = sel_ext ? ext_rise : 1'b1;
  end
endmodule

// File: rtl/tbd_timebase.sv
module tbd_timebase #(
  parameter int TB_W = 64,
  parameter int DW   = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            tick,
  input  logic            wr_lo,
  input  logic            wr_hi,
  input  logic [DW-1:0]   wr_data,
  output logic [TB_W-1:0] tb
);
  localparam int HI_W = TB_W - DW;

  function automatic logic [TB_W-1:0] tb_advance(input logic [TB_W-1:0] v);
    return v + {{(TB_W-1){1'b0}}, 1'b1};
  endfunction

  logic [TB_W-1:0] tb_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tb_q <= '0;
    end else if (wr_lo || wr_hi) begin
      if (wr_lo) tb_q[DW-1:0]    <= wr_data;
      if (wr_hi) tb_q[TB_W-1:DW] <= wr_data[HI_W-1:0];
    end else if (tick) begin
      tb_q <= tb_advance(tb_q);
    end
  end

  assign tb = tb_q;
endmodule

// File: rtl/tbd_decrementer.sv
module tbd_decrementer #(
  parameter int DEC_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             wr_dec,
  input  logic             wr_reload,
  input  logic [DEC_W-1:0] wr_data,
  input  logic             reload_en,
  output logic [DEC_W-1:0] dec,
  output logic             expire
);
  localparam logic [DEC_W-1:0] ONE = {{(DEC_W-1){1'b0}}, 1'b1};

  function automatic logic [DEC_W-1:0] dec_step(
    input logic [DEC_W-1:0] v,
    input logic             are,
    input logic [DEC_W-1:0] rl
  );
    if (v == '0) return are ? rl : '0;
    return v - ONE;
  endfunction

  logic [DEC_W-1:0] dec_q;
  logic [DEC_W-1:0] reload_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         reload_q <= '0;
    else if (wr_reload) reload_q <= wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       dec_q <= '0;
    else if (wr_dec)  dec_q <= wr_data;
    else if (tick)    dec_q <= dec_step(dec_q, reload_en, reload_q);
  end

  assign expire = tick && !wr_dec && (dec_q == ONE);
  assign dec    = dec_q;
endmodule

// File: rtl/tbd_unit.sv
module tbd_unit
  import tbd_pkg::*;
#(
  parameter int TB_W        = 64,
  parameter int DEC_W       = 32,
  parameter int DATA_W      = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_run,
  input  logic              cfg_ext,
  input  logic              ext_tb_clk,
  input  logic              wr_en,
  input  logic [2:0]        wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic [TB_W-1:0]   tb_value,
  output logic [DEC_W-1:0]  dec_value,
  output logic              dec_status,
  output logic              dec_irq
);
  logic tick;
  logic wr_tb_lo, wr_tb_hi, wr_tb_any;
  logic wr_dec, wr_reload, wr_ctrl, wr_stat;
  logic dec_expire;
  logic ctrl_ie_q, ctrl_are_q;
  logic status_q;
  logic [DEC_W-1:0] wr_dec_value;

  assign wr_tb_lo  = wr_en && (wr_addr == ADDR_TB_LO);
  assign wr_tb_hi  = wr_en && (wr_addr == ADDR_TB_HI);
  assign wr_dec    = wr_en && (wr_addr == ADDR_DEC);
  assign wr_reload = wr_en && (wr_addr == ADDR_RELOAD);
  assign wr_ctrl   = wr_en && (wr_addr == ADDR_CTRL);
  assign wr_stat   = wr_en && (wr_addr == ADDR_STAT);
  assign wr_tb_any = wr_tb_lo || wr_tb_hi;
  assign wr_dec_value = wr_data[DEC_W-1:0];

  tbd_tick_gen #(.SYNC_STAGES(SYNC_STAGES)) u_tick (
    .clk     (clk),
    .rst_n   (rst_n),
    .run     (cfg_run),
    .sel_ext (cfg_ext),
    .ext_clk (ext_tb_clk),
    .tick    (tick)
  );

  tbd_timebase #(.TB_W(TB_W), .DW(DATA_W)) u_tb (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick    (tick),
    .wr_lo   (wr_tb_lo),
    .wr_hi   (wr_tb_hi),
    .wr_data (wr_data),
    .tb      (tb_value)
  );

  tbd_decrementer #(.DEC_W(DEC_W)) u_dec (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick      (tick),
    .wr_dec    (wr_dec),
    .wr_reload (wr_reload),
    .wr_data   (wr_dec_value),
    .reload_en (ctrl_are_q),
    .dec       (dec_value),
    .expire    (dec_expire)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_ie_q  <= 1'b0;
      ctrl_are_q <= 1'b0;
    end else if (wr_ctrl) begin
      ctrl_ie_q  <= wr_data[CTRL_IE_BIT];
      ctrl_are_q <= wr_data[CTRL_ARE_BIT];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                status_q <= 1'b0;
    else if (dec_expire)                       status_q <= 1'b1;
    else if (wr_stat && wr_data[STAT_DEC_BIT]) status_q <= 1'b0;
  end

  assign dec_status = status_q;
  assign dec_irq    = status_q & ctrl_ie_q;
endmodule

// File: rtl/tbd_unit_checks.sv
module tbd_unit_checks #(
  parameter int TB_W  = 64,
  parameter int DEC_W = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cfg_run,
  input logic             cfg_ext,
  input logic             tick,
  input logic             wr_tb,
  input logic             wr_dec,
  input logic [DEC_W-1:0] wr_dec_value,
  input logic             are,
  input logic             ie,
  input logic [TB_W-1:0]  tb,
  input logic [DEC_W-1:0] dec,
  input logic             status,
  input logic             irq
);
  localparam logic [TB_W-1:0]  TB_ONE  = {{(TB_W-1){1'b0}}, 1'b1};
  localparam logic [DEC_W-1:0] DEC_ONE = {{(DEC_W-1){1'b0}}, 1'b1};

  assert_idle_no_tick_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_run |-> !tick);

  assert_tb_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !wr_tb) |=> $stable(tb));

  assert_tb_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !wr_tb) |=> (tb == $past(tb) + TB_ONE));

  assert_ext_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_ext && tick) |=> (!tick || !cfg_ext));

  assert_dec_expire_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !wr_dec && dec == DEC_ONE) |=> (status && dec == '0));

  assert_dec_floor_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !wr_dec && !are && dec == '0) |=> (dec == '0));

  assert_irq_gate_R10: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (status && ie));

  assert_write_prio_R11: assert property (@(posedge clk) disable iff (!rst_n)
    wr_dec |=> (dec == $past(wr_dec_value)));
endmodule

bind tbd_unit tbd_unit_checks #(.TB_W(TB_W), .DEC_W(DEC_W)) u_checks (
  .clk          (clk),
  .rst_n        (rst_n),
  .cfg_run      (cfg_run),
  .cfg_ext      (cfg_ext),
  .tick         (tick),
  .wr_tb        (wr_tb_any),
  .wr_dec       (wr_dec),
  .wr_dec_value (wr_dec_value),
  .are          (ctrl_are_q),
  .ie           (ctrl_ie_q),
  .tb           (tb_value),
  .dec          (dec_value),
  .status       (dec_status),
  .irq          (dec_irq)
);

// File: tb/test_tbd_unit.sv
module test_tbd_unit;
  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] IE_MASK  = 32'h0400_0000;
  localparam logic [31:0] ARE_MASK = 32'h0040_0000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_run = 1'b0;
  logic        cfg_ext = 1'b0;
  logic        ext_tb_clk = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_addr = 3'd0;
  logic [31:0] wr_data = 32'd0;
  logic [63:0] tb_value;
  logic [31:0] dec_value;
  logic        dec_status;
  logic        dec_irq;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  tbd_unit i_tbd_unit (
    .clk(clk), .rst_n(rst_n), .cfg_run(cfg_run), .cfg_ext(cfg_ext),
    .ext_tb_clk(ext_tb_clk), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .tb_value(tb_value), .dec_value(dec_value),
    .dec_status(dec_status), .dec_irq(dec_irq)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      @(negedge clk);
    end
  endtask

  task automatic write(input logic [2:0] a, input logic [31:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    step(1);
    wr_en = 1'b0;
  endtask

  function automatic int model_dec(input int v, input bit are, input int rl);
    if (v == 0) return are ? rl : 0;
    return v - 1;
  endfunction

  initial begin
    #(CLK_PERIOD * 100000);
    errors++;
    $display("FAIL watchdog: actual expired expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int m;
    bit seen;
    @(negedge clk); @(negedge clk);
    rst_n = 1'b1;
    step(1);
    // R1 reset state
    check("R1 tb", tb_value, 64'd0);
    check("R1 dec", {32'd0, dec_value}, 64'd0);
    check("R1 status", {63'd0, dec_status}, 64'd0);
    check("R1 irq", {63'd0, dec_irq}, 64'd0);

    // R2 idle
    step(20);
    check("R2 tb idle", tb_value, 64'd0);
    write(3'd2, 32'd7);
    step(5);
    check("R2 dec idle", {32'd0, dec_value}, 64'd7);

    // R3 / R5 core clock counting with carry into high word
    write(3'd0, 32'hFFFF_FFF0);
    cfg_run = 1'b1;
    step(20);
    cfg_run = 1'b0;
    check("R3 R5 carry", tb_value, 64'h1_0000_0004);
    // R5 wrap
    write(3'd1, 32'hFFFF_FFFF);
    write(3'd0, 32'hFFFF_FFFE);
    cfg_run = 1'b1;
    step(3);
    cfg_run = 1'b0;
    check("R5 wrap", tb_value, 64'd1);

    // R6 / R7 decrementer sweep, no reload
    for (int n = 1; n <= 8; n++) begin
      write(3'd2, n);
      write(3'd5, 32'd1);
      cfg_run = 1'b1;
      for (int k = 1; k <= n + 2; k++) begin
        step(1);
        check((k > n) ? "R7 floor" : "R6 count", {32'd0, dec_value}, (n - k > 0) ? 64'(n - k) : 64'd0);
        check("R6 status", {63'd0, dec_status}, (k >= n) ? 64'd1 : 64'd0);
      end
      cfg_run = 1'b0;
    end

    // R8 auto-reload sweep
    write(3'd4, ARE_MASK);
    for (int rl = 0; rl <= 3; rl++) begin
      write(3'd3, rl);
      write(3'd2, 32'd2);
      write(3'd5, 32'd1);
      m = 2;
      seen = 1'b0;
      cfg_run = 1'b1;
      for (int k = 1; k <= 12; k++) begin
        if (m == 1) seen = 1'b1;
        m = model_dec(m, 1'b1, rl);
        step(1);
        check("R8 reload", {32'd0, dec_value}, 64'(m));
        check("R8 status", {63'd0, dec_status}, {63'd0, seen});
      end
      cfg_run = 1'b0;
    end

    // R9 / R10 status and interrupt
    write(3'd4, 32'd0);
    check("R10 irq masked", {63'd0, dec_irq}, 64'd0);
    write(3'd4, IE_MASK);
    check("R10 irq on", {63'd0, dec_irq}, 64'd1);
    write(3'd5, 32'hFFFF_FFFE);
    check("R9 no clear", {63'd0, dec_status}, 64'd1);
    write(3'd5, 32'd1);
    check("R9 clear", {63'd0, dec_status}, 64'd0);
    check("R10 irq off", {63'd0, dec_irq}, 64'd0);
    // R9 set wins over same-cycle clear
    write(3'd2, 32'd1);
    cfg_run = 1'b1;
    write(3'd5, 32'd1);
    cfg_run = 1'b0;
    check("R9 set wins", {63'd0, dec_status}, 64'd1);
    check("R10 irq set", {63'd0, dec_irq}, 64'd1);
    write(3'd4, 32'd0);

    // R11 write priority over tick
    cfg_run = 1'b1;
    write(3'd2, 32'd20);
    check("R11 dec write", {32'd0, dec_value}, 64'd20);
    step(1);
    check("R11 dec after", {32'd0, dec_value}, 64'd19);
    write(3'd1, 32'h0000_0005);
    write(3'd0, 32'h0000_0100);
    check("R11 tb write", tb_value, 64'h5_0000_0100);
    cfg_run = 1'b0;

    // R4 external clock edges
    write(3'd0, 32'd0);
    write(3'd1, 32'd0);
    cfg_ext = 1'b1;
    cfg_run = 1'b1;
    step(6);
    check("R4 no edge", tb_value, 64'd0);
    for (int e = 0; e < 10; e++) begin
      ext_tb_clk = 1'b1; step(3);
      ext_tb_clk = 1'b0; step(3);
    end
    step(5);
    check("R4 edge count", tb_value, 64'd10);
    ext_tb_clk = 1'b1;
    step(12);
    check("R4 held level", tb_value, 64'd11);
    cfg_run = 1'b0;
    cfg_ext = 1'b0;

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule